// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block produces the address that a pattern generator uses to read its vector memory, one address per enabled test-clock cycle. Software picks a run mode before starting: one pass from address zero to the last memory location, an endless pass that wraps from the last location back to zero, or an endless loop over a programmed address window. Independently of the mode, a break address can be armed. When the sequencer reaches it, the sequencer either stops for good or parks until a resume request.

A start request launches a run from the idle state. The step enable paces the run. Each enabled step presents one address, marked by a one-cycle valid strobe. An abort returns the block to idle from any state. A window whose low bound lies above its high bound is rejected at start time, and an error flag records the refusal.

Top module: `vec_addr_seq`

## Requirements
- R1: After reset, addr is 0 and addr_vld, running, paused, done and cfg_err are all 0.
- R2: A start in the idle state (with a valid configuration) sets running on the next edge without presenting an address. The first enabled step then presents address 0 in modes 2'b00 (single pass) and 2'b01 (whole-memory loop), and loop_lo in mode 2'b10 (range loop). Mode 2'b11 behaves as single pass.
- R3: While running, the address changes and addr_vld is 1 only on the edge that follows a cycle with step_en high; on any other cycle addr holds and addr_vld is 0.
- R4: In single-pass mode, the sequencer enters done on the same edge that presents mem_last, and then presents nothing further. This end of pass takes priority over an armed pause at that address.
- R5: In whole-memory loop mode, the address that follows mem_last is 0.
- R6: In range-loop mode, the address that follows loop_hi is loop_lo.
- R7: With brk_en set and brk_pause clear, the sequencer enters done on the edge that presents brk_addr, so the vector at brk_addr is still applied.
- R8: With brk_en and brk_pause set, the sequencer enters paused on the edge that presents brk_addr. It ignores steps while paused. A resume returns it to running, and the next enabled step presents the successor of brk_addr.
- R9: An abort returns the sequencer from any state to idle on the next edge (running, paused and done all 0), with addr_vld 0.
- R10: A start in range-loop mode with loop_lo greater than loop_hi is refused: the sequencer stays idle and cfg_err is set. The next accepted start clears cfg_err.
- R11: At most one of running, paused and done is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advance enable, one address per high cycle |
| start | input | 1 | Begin a run from idle |
| resume | input | 1 | Leave the paused state |
| abort | input | 1 | Return to idle from any state |
| mode | input | 2 | 00 single pass, 01 whole-memory loop, 10 range loop, 11 as 00 |
| loop_lo | input | ADDR_W | Range-loop first address |
| loop_hi | input | ADDR_W | Range-loop last address |
| brk_en | input | 1 | Arm the break address |
| brk_pause | input | 1 | 1: pause at break, 0: halt at break |
| brk_addr | input | ADDR_W | Break address |
| mem_last | input | ADDR_W | Highest populated memory address |
| addr | output | ADDR_W | Current vector address |
| addr_vld | output | 1 | One-cycle strobe for a newly presented address |
| running | output | 1 | Sequencer is stepping |
| paused | output | 1 | Sequencer is parked at a break |
| done | output | 1 | Run ended by halt or end of pass |
| cfg_err | output | 1 | Last start was refused for a bad window |

## Verification
Every result in this block sits one register away from its cause. A status change after start, resume or abort shows on the first edge. An address and its strobe show on the edge that closes the enabled step. A done or paused status after a break or an end of pass shows on that same edge, together with the final address. The bench drives inputs and samples outputs 2 ns after each rising edge, so each check reads the value produced by exactly one edge. Runs of idle cycles between steps confirm that the address holds and the strobe stays low.

// File: rtl/vas_pkg.sv
// Shared types for the vector address sequencer.
package vas_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_RUN   = 2'b01,
        ST_PAUSE = 2'b10,
        ST_DONE  = 2'b11
    } seq_st_e;

    typedef enum logic [1:0] {
        MD_ONCE  = 2'b00,
        MD_WRAP  = 2'b01,
        MD_RANGE = 2'b10,
        MD_RSVD  = 2'b11
    } seq_md_e;
endpackage

// File: rtl/vas_next.sv
// Successor-address function of the sequencer.
// Computes the address that follows cur for the selected mode. pass_end flags
// the last location of a single pass. Purely combinational; it assumes that the
// caller applies the result only on an enabled step.
module vas_next #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] cur,
    input  vas_pkg::seq_md_e  mode,
    input  logic [ADDR_W-1:0] loop_lo,
    input  logic [ADDR_W-1:0] loop_hi,
    input  logic [ADDR_W-1:0] mem_last,
    output logic [ADDR_W-1:0] nxt,
    output logic              pass_end
);
    import vas_pkg::*;

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // Select the wrap target per mode, otherwise increment.
    always_comb begin
        nxt      = cur + ONE;
        pass_end = 1'b0;
        case (mode)
            MD_RANGE: if (cur == loop_hi)  nxt = loop_lo;
            MD_WRAP:  if (cur == mem_last) nxt = '0;
            default:  pass_end = (cur == mem_last);
        endcase
    end
endmodule

// File: rtl/vas_fsm.sv
// Run-state controller of the sequencer.
// Tracks idle/run/paused/done. It accepts a start only from idle with a sound
// configuration and records a refused start in cfg_err. Abort wins over all
// other requests. It assumes that brk_hit and pass_end describe the address
// about to be presented.
module vas_fsm (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             resume,
    input  logic             abort,
    input  logic             step_en,
    input  logic             cfg_bad,
    input  logic             brk_hit,
    input  logic             brk_pause,
    input  logic             pass_end,
    output vas_pkg::seq_st_e state,
    output logic             accept,
    output logic             cfg_err
);
    import vas_pkg::*;

    seq_st_e state_d;

    // A start is taken only in idle, without abort, with a valid window.
    assign accept = (state == ST_IDLE) && start && !abort && !cfg_bad;

    // Next-state selection.
    always_comb begin
        state_d = state;
        case (state)
            ST_IDLE:  if (accept) state_d = ST_RUN;
            ST_RUN:   if (step_en) begin
                          if (pass_end)     state_d = ST_DONE;
                          else if (brk_hit) state_d = brk_pause ? ST_PAUSE : ST_DONE;
                      end
            ST_PAUSE: if (resume) state_d = ST_RUN;
            default:  state_d = ST_DONE;
        endcase
        if (abort) state_d = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Error flag: updated on every start seen in idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_err <= 1'b0;
        else if (state == ST_IDLE && start && !abort)
            cfg_err <= cfg_bad;
    end

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> state == ST_IDLE);

    // R10
    bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && !abort && cfg_bad) |=> (state == ST_IDLE && cfg_err));

    // R8
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE && !resume && !abort) |=> state == ST_PAUSE);
endmodule

// File: rtl/vec_addr_seq.sv
// Vector memory address sequencer (top).
// Holds the next-address pointer and the presented address. On each enabled
// step in the run state it presents the pointer and advances it through
// vas_next. Configuration inputs are assumed stable during a run.
module vec_addr_seq #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              start,
    input  logic              resume,
    input  logic              abort,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] loop_lo,
    input  logic [ADDR_W-1:0] loop_hi,
    input  logic              brk_en,
    input  logic              brk_pause,
    input  logic [ADDR_W-1:0] brk_addr,
    input  logic [ADDR_W-1:0] mem_last,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_vld,
    output logic              running,
    output logic              paused,
    output logic              done,
    output logic              cfg_err
);
    import vas_pkg::*;

    seq_md_e           md;
    seq_st_e           state;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] ptr_nxt;
    logic              pass_end;
    logic              accept;
    logic              cfg_bad;
    logic              brk_hit;
    logic              adv;

    assign md      = seq_md_e'(mode);
    assign cfg_bad = (md == MD_RANGE) && (loop_lo > loop_hi);
    assign brk_hit = brk_en && (ptr == brk_addr);
    assign adv     = (state == ST_RUN) && step_en && !abort;

    vas_next #(.ADDR_W(ADDR_W)) u_next (
        .cur      (ptr),
        .mode     (md),
        .loop_lo  (loop_lo),
        .loop_hi  (loop_hi),
        .mem_last (mem_last),
        .nxt      (ptr_nxt),
        .pass_end (pass_end)
    );

    vas_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .resume    (resume),
        .abort     (abort),
        .step_en   (step_en),
        .cfg_bad   (cfg_bad),
        .brk_hit   (brk_hit),
        .brk_pause (brk_pause),
        .pass_end  (pass_end),
        .state     (state),
        .accept    (accept),
        .cfg_err   (cfg_err)
    );

    // Pointer: loaded with the first address on start, advanced on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= '0;
        else if (accept) ptr <= (md == MD_RANGE) ? loop_lo : '0;
        else if (adv)    ptr <= ptr_nxt;
    end

    // Presented address and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr     <= '0;
            addr_vld <= 1'b0;
        end else begin
            addr_vld <= adv;
            if (adv) addr <= ptr;
        end
    end

    assign running = (state == ST_RUN);
    assign paused  = (state == ST_PAUSE);
    assign done    = (state == ST_DONE);

    // R3
    vld_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld |-> $past(running && step_en));

    // R3
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_vld |-> $stable(addr));

    // R6
    range_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && step_en && !abort && md == MD_RANGE && ptr == loop_hi)
        |=> ptr == $past(loop_lo));

    // R11
    status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({running, paused, done}));
endmodule

// File: tb/vec_addr_seq_tb.sv
module vec_addr_seq_tb;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_en = 1'b0, start = 1'b0, resume = 1'b0, abort = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [AW-1:0] loop_lo = '0, loop_hi = '0, brk_addr = '0, mem_last = '0;
    logic          brk_en = 1'b0, brk_pause = 1'b0;
    logic [AW-1:0] addr;
    logic          addr_vld, running, paused, done, cfg_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vec_addr_seq #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .start(start),
        .resume(resume), .abort(abort), .mode(mode), .loop_lo(loop_lo),
        .loop_hi(loop_hi), .brk_en(brk_en), .brk_pause(brk_pause),
        .brk_addr(brk_addr), .mem_last(mem_last), .addr(addr),
        .addr_vld(addr_vld), .running(running), .paused(paused),
        .done(done), .cfg_err(cfg_err)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic go_idle();
        abort = 1'b1;
        tick();
        abort = 1'b0;
    endtask

    task automatic launch(logic [1:0] m, int lo, int hi, int last,
                          logic be, logic bp, int ba);
        mode = m; loop_lo = AW'(lo); loop_hi = AW'(hi); mem_last = AW'(last);
        brk_en = be; brk_pause = bp; brk_addr = AW'(ba);
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic step(string req, int exp);
        step_en = 1'b1;
        tick();
        step_en = 1'b0;
        chk({req, " vld"}, int'(addr_vld), 1);
        chk({req, " addr"}, int'(addr), exp);
        chk("R11 onehot", $countones({running, paused, done}) <= 1 ? 1 : 0, 1);
    endtask

    task automatic t_reset();
        chk("R1 addr", int'(addr), 0);
        chk("R1 flags", int'({addr_vld, running, paused, done, cfg_err}), 0);
    endtask

    task automatic t_single();
        launch(2'b00, 0, 0, 5, 1'b0, 1'b0, 0);
        chk("R2 running", int'(running), 1);
        chk("R2 no vld", int'(addr_vld), 0);
        for (int i = 0; i <= 5; i++) step("R4 pass", i);
        chk("R4 done", int'(done), 1);
        chk("R4 running", int'(running), 0);
        step_en = 1'b1; tick(); step_en = 1'b0;
        chk("R4 no more vld", int'(addr_vld), 0);
        go_idle();
        // mode 11 acts as single pass, pause at last loses to end of pass
        launch(2'b11, 0, 0, 2, 1'b1, 1'b1, 2);
        for (int i = 0; i <= 2; i++) step("R4 rsvd", i);
        chk("R4 end over pause", int'(done), 1);
        chk("R4 not paused", int'(paused), 0);
        go_idle();
    endtask

    task automatic t_wrap();
        int seq[6] = '{0, 1, 2, 3, 0, 1};
        launch(2'b01, 0, 0, 3, 1'b0, 1'b0, 0);
        for (int i = 0; i < 6; i++) step("R5 wrap", seq[i]);
        chk("R5 running", int'(running), 1);
        go_idle();
    endtask

    task automatic t_range();
        int seq[5] = '{4, 5, 6, 4, 5};
        launch(2'b10, 4, 6, 15, 1'b0, 1'b0, 0);
        for (int i = 0; i < 5; i++) step("R6 range", seq[i]);
        go_idle();
    endtask

    task automatic t_gate();
        launch(2'b01, 0, 0, 15, 1'b0, 1'b0, 0);
        step("R3 first", 0);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R3 idle vld", int'(addr_vld), 0);
            chk("R3 idle addr", int'(addr), 0);
        end
        step("R3 resumed", 1);
        go_idle();
    endtask

    task automatic t_halt();
        launch(2'b01, 0, 0, 15, 1'b1, 1'b0, 3);
        for (int i = 0; i <= 3; i++) step("R7 halt", i);
        chk("R7 done", int'(done), 1);
        step_en = 1'b1; tick(); step_en = 1'b0;
        chk("R7 no vld", int'(addr_vld), 0);
        chk("R7 addr kept", int'(addr), 3);
        abort = 1'b1; tick(); abort = 1'b0;
        chk("R9 from done", int'({running, paused, done}), 0);
    endtask

    task automatic t_pause();
        launch(2'b01, 0, 0, 7, 1'b1, 1'b1, 2);
        for (int i = 0; i <= 2; i++) step("R8 pause", i);
        chk("R8 paused", int'(paused), 1);
        step_en = 1'b1;
        tick();
        chk("R8 ignore vld", int'(addr_vld), 0);
        tick();
        chk("R8 still paused", int'(paused), 1);
        step_en = 1'b0;
        resume = 1'b1; tick(); resume = 1'b0;
        chk("R8 running", int'(running), 1);
        chk("R8 resume no vld", int'(addr_vld), 0);
        step("R8 after resume", 3);
        step("R8 after resume", 4);
        go_idle();
        launch(2'b01, 0, 0, 7, 1'b1, 1'b1, 1);
        step("R8 second", 0);
        step("R8 second", 1);
        abort = 1'b1; tick(); abort = 1'b0;
        chk("R9 from paused", int'({running, paused, done}), 0);
    endtask

    task automatic t_badcfg();
        launch(2'b10, 9, 3, 15, 1'b0, 1'b0, 0);
        chk("R10 err", int'(cfg_err), 1);
        chk("R10 idle", int'(running), 0);
        launch(2'b10, 3, 9, 15, 1'b0, 1'b0, 0);
        chk("R10 err cleared", int'(cfg_err), 0);
        chk("R10 accepted", int'(running), 1);
        step("R2 range first", 3);
        go_idle();
    endtask

    task automatic t_abort();
        launch(2'b01, 0, 0, 15, 1'b0, 1'b0, 0);
        step("R9 pre", 0);
        abort = 1'b1; step_en = 1'b1;
        tick();
        abort = 1'b0; step_en = 1'b0;
        chk("R9 running", int'(running), 0);
        chk("R9 vld", int'(addr_vld), 0);
        launch(2'b01, 0, 0, 15, 1'b0, 1'b0, 0);
        step("R2 restart", 0);
        go_idle();
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_single();
        t_wrap();
        t_range();
        t_gate();
        t_halt();
        t_pause();
        t_badcfg();
        t_abort();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule